// File: doc/BRIEF.md
# Receive/Transmit Interrupt Moderation Timers

This block decides when completion interrupts for a packet engine should be raised. It does not own the interrupt cause register. It watches receive-packet completions and transmit-descriptor completions, runs delay timers for each direction, and hands single-cycle event pulses to the cause controller. Those pulses are a receive-timer event, a transmit-done event and a small-packet event.

Each direction has two timers. The packet timer is reloaded on every qualifying completion, so it expires only after the traffic goes quiet. The absolute timer starts on the first completion of a burst and is never reloaded, so it puts an upper bound on the latency. A shared prescaler produces the timer unit, and every stored value counts in those units. When the cause controller signals that it is posting an interrupt right now, every running timer stops. Each stopped timer reports its event at once, because the posted interrupt already covers the pending work.

Each timer is a two-state machine, with states IDLE and COUNTING. There are four transitions. ARM goes from IDLE to COUNTING on a start with a nonzero value. RELOAD stays in COUNTING and occurs on a start, for the packet timers only. EXPIRE goes from COUNTING to IDLE on the unit tick that takes the count from 1 to zero. CANCEL goes from COUNTING to IDLE when a post-now strobe arrives, and it has priority over RELOAD and EXPIRE.

Top module: `irq_moderation_timers`

## Requirements
- R1: After reset, all stored values are zero, every timer is IDLE, and none of the three event outputs pulses until an input stimulus arrives.
- R2: When the receive packet value N is nonzero, each `rx_pkt_done` restarts the receive packet timer at N units, even if it is already counting. The timer stays silent until N units pass with no further packet.
- R3: When the receive packet value is zero, `ev_rx_timer` pulses in the cycle after each `rx_pkt_done`.
- R4: The receive absolute timer starts on `rx_pkt_done` only if it is IDLE and both the absolute and the packet values are nonzero. Later packets do not reload it. When the packet value is zero, it never starts.
- R5: `ev_small_pkt` pulses in the cycle after `rx_pkt_done` when `rx_pkt_len` is less than or equal to the stored threshold. It does not pulse when the length is larger.
- R6: A write to select 0 with `cfg_wdata[16]` set stores bits 15:0 as the receive packet value and pulses `ev_rx_timer` in the next cycle. The flush bit is not retained, so a later write without it raises no event.
- R7: Transmit timers react only to `tx_desc_done` qualified by `tx_desc_ide`. The transmit packet timer reloads on each qualified descriptor. An unqualified descriptor starts nothing.
- R8: The transmit absolute timer starts on a qualified descriptor only if it is IDLE and both transmit values are nonzero. Later descriptors do not reload it.
- R9: On `irq_post_now`, every COUNTING timer goes to IDLE. In the next cycle `ev_rx_timer` pulses if a receive timer was counting, and `ev_tx_done` pulses if a transmit timer was counting. A cancelled timer never fires afterwards, and a strobe with every timer IDLE raises nothing.
- R10: Configuration selects are 0 for the receive packet value, 1 for the receive absolute value, 2 for the transmit packet value, 3 for the transmit absolute value and 4 for the small-packet threshold. Values are taken from `cfg_wdata[15:0]`.
- R11: A timer loaded with N expires with its event pulse between (N-1)·U+1 and N·U+2 cycles after the loading input, where U is `TICK_DIV`. Every event pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target select (R10) |
| cfg_wdata | input | 17 | Value in bits 15:0, flush request in bit 16 |
| rx_pkt_done | input | 1 | One-cycle strobe: a received packet was stored |
| rx_pkt_len | input | 16 | Length of that packet |
| tx_desc_done | input | 1 | One-cycle strobe: a transmit descriptor completed |
| tx_desc_ide | input | 1 | Delay-enable flag of that descriptor |
| irq_post_now | input | 1 | Cause controller is posting an interrupt this cycle |
| ev_rx_timer | output | 1 | Receive-timer event pulse |
| ev_tx_done | output | 1 | Transmit-done event pulse |
| ev_small_pkt | output | 1 | Small-packet event pulse |

## Verification
A timer stuck in COUNTING, or one that never leaves IDLE, shows at the ports as an event missing from its expected window, or as a spurious pulse on a cancel strobe. Either appears within N·U+2 cycles of the load. A packet timer that fails to reload fires early, measured from the last packet. An absolute timer that reloads fires late, by about one packet spacing per extra packet. A cancel that leaves the state untouched produces a second, stale pulse about N units later. This is why each scenario ends with a quiet window longer than the longest loaded value.

// File: rtl/irqmod_pkg.sv
package irqmod_pkg;
    localparam int unsigned VAL_W_DEF = 16;
    localparam int unsigned NUM_TMR   = 4;
    localparam int unsigned T_RX_PKT  = 0;
    localparam int unsigned T_RX_ABS  = 1;
    localparam int unsigned T_TX_PKT  = 2;
    localparam int unsigned T_TX_ABS  = 3;

    typedef enum logic [2:0] {
        SEL_RX_PKT = 3'd0,
        SEL_RX_ABS = 3'd1,
        SEL_TX_PKT = 3'd2,
        SEL_TX_ABS = 3'd3,
        SEL_SMALL  = 3'd4
    } cfg_sel_e;

    typedef enum logic {
        TMR_IDLE,
        TMR_COUNTING
    } tmr_state_e;
endpackage

// File: rtl/irqmod_prescaler.sv
module irqmod_prescaler #(
    parameter int unsigned DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV < 2) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int unsigned CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;
            logic          tick_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q  <= '0;
                    tick_q <= 1'b0;
                end else begin
                    cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                    tick_q <= (cnt_q == LAST);
                end
            end
            assign tick = tick_q;

            // R11
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_q |=> !tick_q);
        end
    endgenerate
endmodule

// File: rtl/irqmod_timer.sv
module irqmod_timer
    import irqmod_pkg::*;
#(
    parameter int unsigned VAL_W   = VAL_W_DEF,
    parameter bit          RESTART = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             cancel,
    input  logic [VAL_W-1:0] load_val,
    output logic             busy,
    output logic             expired,
    output logic             cancelled
);
    localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

    tmr_state_e       state_q, state_d;
    logic [VAL_W-1:0] cnt_q, cnt_d;
    logic             load_ok;

    assign load_ok = start && (load_val != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TMR_IDLE: begin
                if (load_ok) begin
                    state_d = TMR_COUNTING;
                    cnt_d   = load_val;
                end
            end
            TMR_COUNTING: begin
                if (cancel) begin
                    state_d = TMR_IDLE;
                    cnt_d   = '0;
                end else if (RESTART && load_ok) begin
                    cnt_d = load_val;
                end else if (tick) begin
                    if (cnt_q == ONE) begin
                        state_d = TMR_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            end
        endcase
    end

    always_comb begin
        busy      = 1'b0;
        expired   = 1'b0;
        cancelled = 1'b0;
        unique case (state_q)
            TMR_IDLE: ;
            TMR_COUNTING: begin
                busy      = 1'b1;
                cancelled = cancel;
                expired   = !cancel && !(RESTART && load_ok) && tick && (cnt_q == ONE);
            end
        endcase
    end

    // R9
    cancel_goes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cancelled |=> !busy);

    // R11
    counting_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q != '0));

    // R11
    expire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !expired);
endmodule

// File: rtl/irq_moderation_timers.sv
module irq_moderation_timers
    import irqmod_pkg::*;
#(
    parameter int unsigned VAL_W    = VAL_W_DEF,
    parameter int unsigned TICK_DIV = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [VAL_W:0]   cfg_wdata,
    input  logic             rx_pkt_done,
    input  logic [VAL_W-1:0] rx_pkt_len,
    input  logic             tx_desc_done,
    input  logic             tx_desc_ide,
    input  logic             irq_post_now,
    output logic             ev_rx_timer,
    output logic             ev_tx_done,
    output logic             ev_small_pkt
);
    localparam int unsigned FLUSH_BIT = VAL_W;

    logic [VAL_W-1:0] rx_pkt_q, rx_abs_q, tx_pkt_q, tx_abs_q, small_thr_q;
    logic             unit_tick;
    logic             flush_wr;
    logic             tx_go;

    logic [VAL_W-1:0] ld_val [NUM_TMR];
    logic [NUM_TMR-1:0] tmr_start, tmr_busy, tmr_exp, tmr_can;

    // configuration load path (R10, R6)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_pkt_q    <= '0;
            rx_abs_q    <= '0;
            tx_pkt_q    <= '0;
            tx_abs_q    <= '0;
            small_thr_q <= '0;
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_RX_PKT: rx_pkt_q    <= cfg_wdata[VAL_W-1:0];
                SEL_RX_ABS: rx_abs_q    <= cfg_wdata[VAL_W-1:0];
                SEL_TX_PKT: tx_pkt_q    <= cfg_wdata[VAL_W-1:0];
                SEL_TX_ABS: tx_abs_q    <= cfg_wdata[VAL_W-1:0];
                SEL_SMALL:  small_thr_q <= cfg_wdata[VAL_W-1:0];
                default: ;
            endcase
        end
    end

    assign flush_wr = cfg_we && (cfg_sel == SEL_RX_PKT) && cfg_wdata[FLUSH_BIT];
    assign tx_go    = tx_desc_done && tx_desc_ide;

    irqmod_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (unit_tick)
    );

    // start qualification: absolute timers need the packet value enabled too
    always_comb begin
        tmr_start[T_RX_PKT] = rx_pkt_done;
        tmr_start[T_RX_ABS] = rx_pkt_done && (rx_pkt_q != '0);
        tmr_start[T_TX_PKT] = tx_go;
        tmr_start[T_TX_ABS] = tx_go && (tx_pkt_q != '0);
        ld_val[T_RX_PKT]    = rx_pkt_q;
        ld_val[T_RX_ABS]    = rx_abs_q;
        ld_val[T_TX_PKT]    = tx_pkt_q;
        ld_val[T_TX_ABS]    = tx_abs_q;
    end

    generate
        for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
            irqmod_timer #(
                .VAL_W  (VAL_W),
                .RESTART((i % 2) == 0)
            ) u_tmr (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick     (unit_tick),
                .start    (tmr_start[i]),
                .cancel   (irq_post_now),
                .load_val (ld_val[i]),
                .busy     (tmr_busy[i]),
                .expired  (tmr_exp[i]),
                .cancelled(tmr_can[i])
            );
        end
    endgenerate

    logic rx_ev_d, tx_ev_d, small_ev_d;

    always_comb begin
        rx_ev_d = tmr_exp[T_RX_PKT] | tmr_exp[T_RX_ABS]
                | tmr_can[T_RX_PKT] | tmr_can[T_RX_ABS]
                | (rx_pkt_done && (rx_pkt_q == '0))
                | flush_wr;
        tx_ev_d = tmr_exp[T_TX_PKT] | tmr_exp[T_TX_ABS]
                | tmr_can[T_TX_PKT] | tmr_can[T_TX_ABS];
        small_ev_d = rx_pkt_done && (rx_pkt_len <= small_thr_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_rx_timer  <= 1'b0;
            ev_tx_done   <= 1'b0;
            ev_small_pkt <= 1'b0;
        end else begin
            ev_rx_timer  <= rx_ev_d;
            ev_tx_done   <= tx_ev_d;
            ev_small_pkt <= small_ev_d;
        end
    end

    // R3
    rx_zero_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pkt_done && rx_pkt_q == '0) |=> ev_rx_timer);

    // R5
    small_needs_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_pkt_done |=> !ev_small_pkt);

    // R6
    flush_posts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_wr |=> ev_rx_timer);

    // R9
    cancel_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_post_now && (tmr_busy[T_RX_PKT] || tmr_busy[T_RX_ABS])) |=> ev_rx_timer);

    // R9
    cancel_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_post_now && (tmr_busy[T_TX_PKT] || tmr_busy[T_TX_ABS])) |=> ev_tx_done);

    // R7
    tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_busy == '0 && !irq_post_now) |=> !ev_tx_done);
endmodule

// File: tb/test_irq_moderation_timers.sv
module test_irq_moderation_timers;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int W          = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [W:0]    cfg_wdata = '0;
    logic          rx_pkt_done = 1'b0;
    logic [W-1:0]  rx_pkt_len = '0;
    logic          tx_desc_done = 1'b0;
    logic          tx_desc_ide = 1'b0;
    logic          irq_post_now = 1'b0;
    logic          ev_rx_timer, ev_tx_done, ev_small_pkt;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_moderation_timers #(.VAL_W(W), .TICK_DIV(DIV)) i_irq_moderation_timers (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rx_pkt_done(rx_pkt_done), .rx_pkt_len(rx_pkt_len),
        .tx_desc_done(tx_desc_done), .tx_desc_ide(tx_desc_ide),
        .irq_post_now(irq_post_now), .ev_rx_timer(ev_rx_timer),
        .ev_tx_done(ev_tx_done), .ev_small_pkt(ev_small_pkt)
    );

    function automatic bit sample(input int which);
        case (which)
            0: return ev_rx_timer;
            1: return ev_tx_done;
            2: return ev_small_pkt;
            default: return ev_rx_timer | ev_tx_done;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // all drive tasks start and end at a negedge; the cycle after the drive is n=1
    task automatic cfg_write(input int sel, input logic [W:0] data);
        cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic rx_pkt(input int len);
        rx_pkt_done = 1'b1; rx_pkt_len = W'(len);
        @(negedge clk);
        rx_pkt_done = 1'b0;
    endtask

    task automatic tx_desc(input bit ide);
        tx_desc_done = 1'b1; tx_desc_ide = ide;
        @(negedge clk);
        tx_desc_done = 1'b0; tx_desc_ide = 1'b0;
    endtask

    task automatic post_now();
        irq_post_now = 1'b1;
        @(negedge clk);
        irq_post_now = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_event(input int which, input int lo, input int hi, input string req);
        int got = -1;
        for (int n = 1; n <= hi + 4; n++) begin
            if (sample(which)) begin got = n; break; end
            @(negedge clk);
        end
        check(got >= lo && got <= hi, req, got, lo);
        @(negedge clk);
        check(!sample(which), {req, " pulse width (R11)"}, int'(sample(which)), 0);
    endtask

    task automatic expect_quiet(input int which, input int n, input string req);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            if (sample(which)) hits++;
            @(negedge clk);
        end
        check(hits == 0, req, hits, 0);
    endtask

    task automatic t_reset();
        expect_quiet(3, 30, "R1 no rx/tx event after reset");
        expect_quiet(2, 5, "R1 no small event after reset");
    endtask

    task automatic t_rx_zero();
        rx_pkt(100);
        expect_event(0, 1, 1, "R3 immediate rx event with zero delay");
        expect_quiet(0, 10, "R3 single event per packet");
    endtask

    task automatic t_abs_needs_pkt_value();
        cfg_write(1, 17'd3);
        rx_pkt(100);
        expect_event(0, 1, 1, "R3 immediate event");
        expect_quiet(0, 30, "R4 absolute timer idle when packet value zero");
        cfg_write(1, 17'd0);
    endtask

    task automatic t_small();
        cfg_write(4, 17'd64);
        rx_pkt(64);
        expect_event(2, 1, 1, "R5 length equal to threshold");
        rx_pkt(65);
        expect_quiet(2, 5, "R5 length above threshold");
        rx_pkt(3);
        expect_event(2, 1, 1, "R5 length below threshold");
        cfg_write(4, 17'd0);
        idle(3);
    endtask

    task automatic t_rx_restart();
        cfg_write(0, 17'd5);
        rx_pkt(100);
        expect_quiet(0, 11, "R2 no event before reload");
        rx_pkt(100);
        expect_event(0, 17, 22, "R2 timer measured from last packet");
        expect_quiet(0, 30, "R2 no extra event");
    endtask

    task automatic t_rx_abs();
        cfg_write(0, 17'd10);
        cfg_write(1, 17'd6);
        rx_pkt(100); idle(7);
        rx_pkt(100); idle(7);
        rx_pkt(100);
        expect_event(0, 4, 11, "R4 absolute bound from first packet");
        post_now();
        expect_event(0, 1, 1, "R9 cancel of remaining rx packet timer");
        expect_quiet(0, 60, "R9 cancelled rx timer stays silent");
        cfg_write(1, 17'd0);
    endtask

    task automatic t_flush();
        cfg_write(0, 17'h1_0003);
        expect_event(0, 1, 1, "R6 flush write posts");
        expect_quiet(0, 20, "R6 no event after flush without packet");
        cfg_write(0, 17'h0_0003);
        expect_quiet(0, 20, "R6 flush bit not retained");
        rx_pkt(100);
        expect_event(0, 9, 14, "R10 value stored through select 0");
    endtask

    task automatic t_tx();
        cfg_write(2, 17'd4);
        tx_desc(1'b0);
        expect_quiet(1, 40, "R7 descriptor without delay-enable ignored");
        tx_desc(1'b1);
        expect_event(1, 13, 18, "R7 tx packet timer expiry");
        cfg_write(2, 17'd9);
        cfg_write(3, 17'd6);
        tx_desc(1'b1); idle(7);
        tx_desc(1'b1); idle(7);
        tx_desc(1'b1);
        expect_event(1, 4, 11, "R8 tx absolute bound from first descriptor");
        post_now();
        expect_event(1, 1, 1, "R9 cancel of remaining tx packet timer");
        expect_quiet(1, 50, "R9 cancelled tx timer stays silent");
        cfg_write(3, 17'd0);
    endtask

    task automatic t_cancel();
        cfg_write(0, 17'd20);
        cfg_write(2, 17'd20);
        rx_pkt(100);
        tx_desc(1'b1);
        idle(8);
        post_now();
        check(ev_rx_timer == 1'b1, "R9 rx cancel event", int'(ev_rx_timer), 1);
        check(ev_tx_done == 1'b1, "R9 tx cancel event", int'(ev_tx_done), 1);
        @(negedge clk);
        expect_quiet(3, 100, "R9 no late expiry after cancel");
        post_now();
        expect_quiet(3, 5, "R9 post with idle timers raises nothing");
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_zero();
        t_abs_needs_pkt_value();
        t_small();
        t_rx_restart();
        t_rx_abs();
        t_flush();
        t_tx();
        t_cancel();
        finish_run();
    end
endmodule